// File: doc/BRIEF.md
# Transmit Audio Channel Interrupt Status Unit

This block turns the FIFO and transmitter status of one transmit audio channel into interrupt status bits. It drives a single level-sensitive interrupt line from them. The block holds one sticky flag of its own: the underrun flag. A drain event that finds the FIFO empty raises the flag, and the flag drops only when software writes the clear register with the underrun-clear bit set. The other sources come straight from the FIFO status pins: the half-empty flag, and an empty FIFO while the transmitter is idle.

The interrupt status is not a latch of past events. It is rebuilt from the current flags in every cycle that carries a refresh. A refresh is any write to the enable or clear register, any drain event, or an underrun event. Between refreshes the status holds its value. An enable register masks the status. The interrupt line is registered, so it follows a change of status or enable one clock later. The bus decoding and the FIFO sit outside the block. They reach it through plain strobes and level inputs. The block has no streaming data path, so no valid/ready handshake is needed.

Top module: `aud_irq_unit`

## Requirements
- R1: After reset the enable register, the interrupt status, the underrun flag and `irq_o` are all zero.
- R2: An `urun_set` pulse sets the underrun flag at the next edge. A clear-register write with bit 2 set clears the flag. A clear write with bit 2 at zero leaves it set.
- R3: If `urun_set` and a clear write with bit 2 set fall in the same cycle, the flag ends set.
- R4: The status register is rebuilt only in a refresh cycle (`ien_we`, `clr_we`, `drain_evt` or `urun_set` high). In any other cycle it holds, even when the flag inputs change.
- R5: Status bit 2 (underrun) equals the underrun flag value in force after that cycle's set and clear.
- R6: Status bit 1 (transmit) equals `half_empty` in the refresh cycle.
- R7: Status bit 0 (transmit complete) is 1 only when `fifo_empty` is 1 and `tx_busy` is 0 in the refresh cycle.
- R8: Status bits 6 to 3 always read zero.
- R9: `irq_o` equals the OR of (status AND enable) as held after the previous edge. It therefore changes one clock after the status or the enable register changes.
- R10: `all_rd_o` returns the status in its low 7 bits, with all higher bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drain_evt | input | 1 | FIFO drain event; triggers a refresh |
| urun_set | input | 1 | Underrun event: sets the underrun flag and triggers a refresh |
| half_empty | input | 1 | FIFO half-empty flag |
| fifo_empty | input | 1 | FIFO empty flag |
| tx_busy | input | 1 | Transmitter busy flag |
| ien_we | input | 1 | Enable-register write strobe |
| ien_wdata | input | 7 | Enable-register write data |
| clr_we | input | 1 | Clear-register write strobe |
| clr_wdata | input | 7 | Clear-register write data; bit 2 clears the underrun flag |
| urun_flag_o | output | 1 | Underrun flag |
| int_status_o | output | 7 | Interrupt status (bit 0 complete, bit 1 transmit, bit 2 underrun) |
| irq_o | output | 1 | Registered, masked interrupt line |
| all_rd_o | output | RD_W | Combined read view of the interrupt status |

## Verification
An underrun event and a clear write with the underrun-clear bit set can land in the same clock. The bench raises `urun_set` and a clear write of 0x04 in one cycle. It then expects the underrun flag and status bit 2 to be high after that edge. A refresh can also coincide with a change of the enable mask. Every table vector writes a new mask together with new flag levels. The bench checks the status after the first edge and the line only after the second, so the one-cycle lag of the line is visible.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int IRQ_W  = 7;
  localparam int BIT_TC = 0;
  localparam int BIT_TX = 1;
  localparam int BIT_UR = 2;
  localparam int NUM_SRC = 3;
endpackage

// File: rtl/aud_urun_flag.sv
module aud_urun_flag
  import aud_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] clr_wdata_i,
  output logic             flag_o,
  output logic             flag_nxt_o
);
  logic flag_q;
  logic clr_hit;

  assign clr_hit = clr_we_i & clr_wdata_i[BIT_UR];

  // set is applied after clear, so a coincident event survives
  always_comb begin
    flag_nxt_o = flag_q;
    if (clr_hit) flag_nxt_o = 1'b0;
    if (set_i)   flag_nxt_o = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_nxt_o;
  end

  assign flag_o = flag_q;

  assert_clr_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_i) |=> !flag_o);
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_hit) |=> flag_o);
endmodule

// File: rtl/aud_irq_status.sv
module aud_irq_status
  import aud_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refresh_i,
  input  logic             urun_i,
  input  logic             half_empty_i,
  input  logic             fifo_empty_i,
  input  logic             tx_busy_i,
  output logic [IRQ_W-1:0] status_o
);
  logic [IRQ_W-1:0] status_q;
  logic [IRQ_W-1:0] status_nxt;

  always_comb begin
    status_nxt         = '0;
    status_nxt[BIT_TC] = fifo_empty_i & ~tx_busy_i;
    status_nxt[BIT_TX] = half_empty_i;
    status_nxt[BIT_UR] = urun_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         status_q <= '0;
    else if (refresh_i) status_q <= status_nxt;
  end

  assign status_o = status_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_i |=> $stable(status_o));
  assert_tc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_i && tx_busy_i) |=> !status_o[BIT_TC]);
  assert_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_i |=> (status_o[BIT_TX] == $past(half_empty_i)));
  assert_resv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[IRQ_W-1:NUM_SRC] == '0);
endmodule

// File: rtl/aud_irq_line.sv
module aud_irq_line
  import aud_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_we_i,
  input  logic [IRQ_W-1:0] ien_wdata_i,
  input  logic [IRQ_W-1:0] status_i,
  output logic             irq_o
);
  logic [IRQ_W-1:0] ien_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ien_we_i) ien_q <= ien_wdata_i;
      irq_q <= |(status_i & ien_q);
    end
  end

  assign irq_o = irq_q;

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_we_i && ien_wdata_i == '0) |=> ##1 !irq_o);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i == '0) |=> !irq_o);
endmodule

// File: rtl/aud_irq_unit.sv
module aud_irq_unit
  import aud_irq_pkg::*;
#(
  parameter int RD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drain_evt,
  input  logic             urun_set,
  input  logic             half_empty,
  input  logic             fifo_empty,
  input  logic             tx_busy,
  input  logic             ien_we,
  input  logic [IRQ_W-1:0] ien_wdata,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_wdata,
  output logic             urun_flag_o,
  output logic [IRQ_W-1:0] int_status_o,
  output logic             irq_o,
  output logic [RD_W-1:0]  all_rd_o
);
  localparam int RD_PAD = RD_W - IRQ_W;
  localparam logic [IRQ_W-1:0] RD_MASK = '1;

  logic flag_nxt;
  logic refresh;

  assign refresh = ien_we | clr_we | drain_evt | urun_set;

  aud_urun_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (urun_set),
    .clr_we_i   (clr_we),
    .clr_wdata_i(clr_wdata),
    .flag_o     (urun_flag_o),
    .flag_nxt_o (flag_nxt)
  );

  aud_irq_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .refresh_i   (refresh),
    .urun_i      (flag_nxt),
    .half_empty_i(half_empty),
    .fifo_empty_i(fifo_empty),
    .tx_busy_i   (tx_busy),
    .status_o    (int_status_o)
  );

  aud_irq_line u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien_we_i   (ien_we),
    .ien_wdata_i(ien_wdata),
    .status_i   (int_status_o),
    .irq_o      (irq_o)
  );

  generate
    if (RD_PAD > 0) begin : g_pad
      assign all_rd_o = {{RD_PAD{1'b0}}, int_status_o & RD_MASK};
    end else begin : g_nopad
      assign all_rd_o = int_status_o[RD_W-1:0];
    end
  endgenerate

  assert_ur_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (int_status_o[BIT_UR] == urun_flag_o));
  assert_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    all_rd_o[IRQ_W-1:0] == int_status_o);
endmodule

// File: tb/test_aud_irq_unit.sv
module test_aud_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       drain_evt, urun_set, half_empty, fifo_empty, tx_busy;
  logic       ien_we, clr_we;
  logic [6:0] ien_wdata, clr_wdata;
  logic       urun_flag_o, irq_o;
  logic [6:0] int_status_o;
  logic [31:0] all_rd_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  aud_irq_unit i_aud_irq_unit (
    .clk(clk), .rst_n(rst_n), .drain_evt(drain_evt), .urun_set(urun_set),
    .half_empty(half_empty), .fifo_empty(fifo_empty), .tx_busy(tx_busy),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .urun_flag_o(urun_flag_o),
    .int_status_o(int_status_o), .irq_o(irq_o), .all_rd_o(all_rd_o)
  );

  // vector layout: {ien[6:0], half_empty, fifo_empty, tx_busy}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {7'h00, 3'b110}, {7'h01, 3'b010}, {7'h01, 3'b011}, {7'h02, 3'b101},
    {7'h05, 3'b100}, {7'h7F, 3'b000}, {7'h04, 3'b110}, {7'h03, 3'b111}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    drain_evt = 0; urun_set = 0; ien_we = 0; clr_we = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] exp_st;
    rst_n = 0; idle(); half_empty = 0; fifo_empty = 0; tx_busy = 0;
    ien_wdata = 0; clr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(int_status_o == 0, "R1 status", int_status_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    chk(urun_flag_o == 0, "R1 flag", urun_flag_o, 0);
    // R1 enable zero: refresh with all flags true, line must stay low
    half_empty = 1; fifo_empty = 1; drain_evt = 1;
    @(negedge clk); idle();
    @(negedge clk);
    chk(irq_o == 0, "R1 enable zero", irq_o, 0);

    // vector walk: R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      ien_wdata = VEC[i][9:3]; half_empty = VEC[i][2];
      fifo_empty = VEC[i][1]; tx_busy = VEC[i][0];
      ien_we = 1; drain_evt = 1;
      exp_st = {4'b0000, 1'b0, VEC[i][2], VEC[i][1] & ~VEC[i][0]};
      @(negedge clk); idle();
      chk(int_status_o == exp_st, "R6/R7/R8 status", int_status_o, exp_st);
      chk(all_rd_o == {25'd0, exp_st}, "R10 read", all_rd_o, {25'd0, exp_st});
      @(negedge clk);
      chk(irq_o == |(exp_st & VEC[i][9:3]), "R9 irq", irq_o,
          |(exp_st & VEC[i][9:3]));
    end

    // R2 set, enable underrun only
    half_empty = 0; fifo_empty = 0; tx_busy = 0;
    ien_wdata = 7'h04; ien_we = 1;
    @(negedge clk); idle();
    urun_set = 1;
    @(negedge clk); idle();
    chk(urun_flag_o == 1, "R2 set", urun_flag_o, 1);
    chk(int_status_o == 7'h04, "R5 status ur", int_status_o, 7'h04);
    @(negedge clk);
    chk(irq_o == 1, "R9 irq ur", irq_o, 1);
    // R2 clear without bit 2
    clr_wdata = 7'h03; clr_we = 1;
    @(negedge clk); idle();
    chk(urun_flag_o == 1, "R2 clear ignored", urun_flag_o, 1);
    chk(int_status_o[2] == 1, "R5 status kept", int_status_o[2], 1);
    // R2 clear with bit 2, line follows one cycle later (R9)
    clr_wdata = 7'h04; clr_we = 1;
    @(negedge clk); idle();
    chk(urun_flag_o == 0, "R2 clear", urun_flag_o, 0);
    chk(int_status_o == 0, "R5 status cleared", int_status_o, 0);
    chk(irq_o == 1, "R9 lag", irq_o, 1);
    @(negedge clk);
    chk(irq_o == 0, "R9 fall", irq_o, 0);
    // R3 set and clear together
    urun_set = 1; clr_wdata = 7'h04; clr_we = 1;
    @(negedge clk); idle();
    chk(urun_flag_o == 1, "R3 set wins", urun_flag_o, 1);
    chk(int_status_o[2] == 1, "R3 status", int_status_o[2], 1);
    // R4 no refresh: flag inputs change, status holds
    half_empty = 1; fifo_empty = 1;
    repeat (3) @(negedge clk);
    chk(int_status_o == 7'h04, "R4 hold", int_status_o, 7'h04);
    drain_evt = 1;
    @(negedge clk); idle();
    chk(int_status_o == 7'h07, "R4 refresh", int_status_o, 7'h07);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule